// File: doc/BRIEF.md
# Multiplexed Backplane Bus Master

This block sits between a 16-bit processor's local bus and a 32-bit synchronous backplane whose address and data share one set of lines. An external access spends one bus clock with the 28-bit physical address on the shared lines and a one-clock start strobe. It then spends one or more clocks in the data phase, until the addressed target returns an acknowledge. The processor is held with a ready/wait signal while its access is in flight. Accesses flagged as on-board never reach the backplane and complete in the clock they are presented.

A write that the processor marks as a destination-operand cycle goes into a one-entry posted buffer. The processor is released in the same clock, and the buffered write then runs on the backplane by itself. A later external access that arrives while that write is still in flight is held until it drains. A data phase that sees no acknowledge for a parameterised number of clocks is abandoned. Any waiting processor read is then released with all-ones data, and a one-clock error pulse is raised.

Top module: `bpbus_master`

## Requirements
- R1: After reset, with no request, `bp_start`, `bp_ad_oe`, `bus_err` and `cpu_ready` are all 0.
- R2: In the clock after an idle block accepts an external request, `bp_start` is 1 for exactly one clock. In that clock `bp_ad_o[27:0]` holds the request address, `bp_ad_o[31:28]` is 0, `bp_ad_oe` is 1 and `bp_write` equals the request's write flag.
- R3: The data phase starts in the clock after the address clock. During a write's data phase, `bp_ad_oe` is 1 and the write data is on the shared lines.
- R4: The data phase repeats while `bp_ack` is 0 and ends in the clock where it is 1. A read or non-posted write therefore shows `cpu_ready` 2+W clocks after it is presented to an idle block, where W is the number of wait clocks.
- R5: Read data is taken from the 16-bit lane chosen by address bit 1: bit 1 = 0 selects `bp_ad_i[15:0]` and bit 1 = 1 selects `bp_ad_i[31:16]`. It is shown on `cpu_rdata` with `cpu_ready` in the acknowledge clock.
- R6: Write data is placed on the lane chosen by address bit 1, with the same encoding as R5. The other lane is driven with 0.
- R7: An external write with `cpu_dop`=1 presented to an idle block gets `cpu_ready` in that same clock, and then completes on the backplane by itself.
- R8: An external request presented while a posted write is still in flight gets no `cpu_ready` until that write has been acknowledged and the new access has itself completed. For a following read this takes 4+2W clocks when both transfers see W waits.
- R9: A request with `cpu_local`=1 gets `cpu_ready` in the clock it is presented, even while a backplane transfer is in flight.
- R10: After 255 data clocks without acknowledge the transfer is abandoned. A waiting read is released with `cpu_rdata` = 16'hFFFF, and `bus_err` is 1 for exactly the following clock.
- R11: A write with `cpu_dop`=0 is not posted: it holds the processor until the acknowledge clock, as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (the processor clock output) |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_local | input | 1 | Access targets on-board memory |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_dop | input | 1 | Write is a destination-operand cycle (may be posted) |
| cpu_addr | input | 28 | Physical byte address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete / processor may proceed |
| bp_ad_o | output | 32 | Shared address/data lines, driven value |
| bp_ad_oe | output | 1 | Drive enable for the shared lines |
| bp_ad_i | input | 32 | Shared address/data lines, sampled value |
| bp_start | output | 1 | Address-clock strobe |
| bp_write | output | 1 | Transfer direction during a transfer |
| bp_ack | input | 1 | Target acknowledge in the data phase |
| bus_err | output | 1 | One-clock pulse on an abandoned transfer |

## Verification
The bench builds the block with its defaults: a 28-bit address, a 32-bit bus split into two 16-bit lanes, and an acknowledge limit of 255. The two lanes let both values of address bit 1 reach the read mux and the write placement. The 255-clock limit keeps a full timeout inside a few hundred clocks, so the abandon path and the error pulse are run in full. A target model with wait counts of 0, 1, 2 and 3 exposes the posted-write drain timing and the hold on accesses that follow it.

// File: rtl/bpbus_pkg.sv
package bpbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } bp_state_e;
endpackage

// File: rtl/bpbus_lane.sv
// Places a narrow word on one lane of the wide bus and picks it back out.
module bpbus_lane #(
   parameter int BUS_W = 32,
   parameter int CPU_W = 16,
   localparam int LANES = BUS_W / CPU_W,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [CPU_W-1:0] wdata,
   output logic [BUS_W-1:0] wbus,
   input  logic [BUS_W-1:0] rbus,
   output logic [CPU_W-1:0] rdata
);
   generate
      if (LANES == 1) begin : g_single
         assign wbus  = wdata;
         assign rdata = rbus;
      end else begin : g_multi
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign wbus[i*CPU_W +: CPU_W] = (sel == SEL_W'(i)) ? wdata : '0;
         end
         assign rdata = rbus[sel*CPU_W +: CPU_W];
      end
   endgenerate
endmodule

// File: rtl/bpbus_ack_wdog.sv
// Counts data-phase clocks and flags the one where the limit is reached.
module bpbus_ack_wdog #(
   parameter int LIMIT = 255,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic ack,
   output logic expire
);
   logic [CNT_W-1:0] cnt;

   assign expire = active & ~ack & (cnt == CNT_W'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (active & ~ack & ~expire)
         cnt <= cnt + 1'b1;
      else
         cnt <= '0;
   end
endmodule

// File: rtl/bpbus_master.sv
module bpbus_master #(
   parameter int ADDR_W    = 28,
   parameter int BUS_W     = 32,
   parameter int CPU_W     = 16,
   parameter int ACK_LIMIT = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_local,
   input  logic              cpu_we,
   input  logic              cpu_dop,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [CPU_W-1:0]  cpu_wdata,
   output logic [CPU_W-1:0]  cpu_rdata,
   output logic              cpu_ready,
   output logic [BUS_W-1:0]  bp_ad_o,
   output logic              bp_ad_oe,
   input  logic [BUS_W-1:0]  bp_ad_i,
   output logic              bp_start,
   output logic              bp_write,
   input  logic              bp_ack,
   output logic              bus_err
);
   import bpbus_pkg::*;

   localparam int LANES   = BUS_W / CPU_W;
   localparam int SEL_W   = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int SEL_LSB = $clog2(CPU_W / 8);

   generate
      if ((BUS_W % CPU_W) != 0 || (CPU_W % 8) != 0 || ADDR_W > BUS_W ||
          ADDR_W < SEL_LSB + SEL_W || ACK_LIMIT < 1) begin : g_bad_cfg
         $error("bpbus_master: unsupported parameter combination");
      end
   endgenerate

   bp_state_e         state;
   logic [ADDR_W-1:0] t_addr;
   logic [CPU_W-1:0]  t_wdata;
   logic              t_we;
   logic              t_posted;
   logic              err_q;

   logic ext_req, accept, post_now, in_data, expire, finish;
   logic [BUS_W-1:0] lane_wbus;
   logic [CPU_W-1:0] lane_rd;

   assign ext_req  = cpu_req & ~cpu_local;
   assign accept   = (state == ST_IDLE) & ext_req;
   assign post_now = accept & cpu_we & cpu_dop;
   assign in_data  = (state == ST_DATA);
   assign finish   = in_data & (bp_ack | expire);

   bpbus_lane #(.BUS_W(BUS_W), .CPU_W(CPU_W)) u_lane (
      .sel   (t_addr[SEL_LSB +: SEL_W]),
      .wdata (t_wdata),
      .wbus  (lane_wbus),
      .rbus  (bp_ad_i),
      .rdata (lane_rd)
   );

   bpbus_ack_wdog #(.LIMIT(ACK_LIMIT)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (in_data),
      .ack    (bp_ack),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         t_addr   <= '0;
         t_wdata  <= '0;
         t_we     <= 1'b0;
         t_posted <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= expire;
         unique case (state)
            ST_IDLE: if (accept) begin
               state    <= ST_ADDR;
               t_addr   <= cpu_addr;
               t_wdata  <= cpu_wdata;
               t_we     <= cpu_we;
               t_posted <= post_now;
            end
            ST_ADDR: state <= ST_DATA;
            ST_DATA: if (finish) begin
               state    <= ST_IDLE;
               t_posted <= 1'b0;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bp_ad_o = '0;
      if (state == ST_ADDR)
         bp_ad_o = BUS_W'(t_addr);
      else if (in_data & t_we)
         bp_ad_o = lane_wbus;
   end

   assign bp_ad_oe  = (state == ST_ADDR) | (in_data & t_we);
   assign bp_start  = (state == ST_ADDR);
   assign bp_write  = t_we & (state != ST_IDLE);
   assign bus_err   = err_q;
   assign cpu_ready = (cpu_req & cpu_local) | post_now | (finish & ~t_posted);
   assign cpu_rdata = bp_ack ? lane_rd : '1;
endmodule

// File: rtl/bpbus_master_chk.sv
module bpbus_master_chk #(
   parameter int ADDR_W = 28,
   parameter int BUS_W  = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cpu_req,
   input logic                  cpu_local,
   input logic                  cpu_ready,
   input logic [BUS_W-1:0]      bp_ad_o,
   input logic                  bp_ad_oe,
   input logic                  bp_start,
   input logic                  bp_ack,
   input logic                  bus_err,
   input bpbus_pkg::bp_state_e  st
);
   import bpbus_pkg::*;

   assert_start_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bp_start |=> !bp_start);

   assert_addr_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bp_start |-> (bp_ad_oe && ((bp_ad_o >> ADDR_W) == '0)));

   assert_ack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && bp_ack) |=> (st == ST_IDLE));

   assert_addr_then_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bp_start |=> (st == ST_DATA));

   assert_busy_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && cpu_req && !cpu_local) |-> !cpu_ready);

   assert_local_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_local) |-> cpu_ready);

   assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> !bus_err);

   assert_err_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_err) |-> $past(st == ST_DATA && !bp_ack));
endmodule

bind bpbus_master bpbus_master_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_local (cpu_local),
   .cpu_ready (cpu_ready),
   .bp_ad_o   (bp_ad_o),
   .bp_ad_oe  (bp_ad_oe),
   .bp_start  (bp_start),
   .bp_ack    (bp_ack),
   .bus_err   (bus_err),
   .st        (state)
);

// File: tb/bpbus_master_tb.sv
module bpbus_master_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_local = 1'b0, cpu_we = 1'b0, cpu_dop = 1'b0;
   logic [27:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        cpu_ready;
   logic [31:0] bp_ad_o, bp_ad_i;
   logic        bp_ad_oe, bp_start, bp_write, bp_ack, bus_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bpbus_master u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_local(cpu_local),
      .cpu_we(cpu_we), .cpu_dop(cpu_dop), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .bp_ad_o(bp_ad_o), .bp_ad_oe(bp_ad_oe), .bp_ad_i(bp_ad_i),
      .bp_start(bp_start), .bp_write(bp_write), .bp_ack(bp_ack),
      .bus_err(bus_err)
   );

   // ---------------- target model ----------------
   logic [31:0] tmem [0:63];
   logic [15:0] ref16 [0:127];
   logic        tgt_in_data = 1'b0;
   logic        tgt_we = 1'b0;
   logic [27:0] tgt_addr = '0;
   int          tgt_cnt = 0;
   int          wait_n = 0;
   bit          no_ack = 0;

   assign bp_ack  = tgt_in_data && !no_ack && (tgt_cnt == wait_n);
   assign bp_ad_i = tmem[tgt_addr[7:2]];

   always @(posedge clk) begin
      if (!rst_n) begin
         tgt_in_data <= 1'b0;
         tgt_cnt     <= 0;
      end else if (bp_start) begin
         tgt_in_data <= 1'b1;
         tgt_cnt     <= 0;
         tgt_addr    <= bp_ad_o[27:0];
         tgt_we      <= bp_write;
      end else if (tgt_in_data) begin
         if (bp_ack) begin
            tgt_in_data <= 1'b0;
            if (tgt_we) begin
               if (tgt_addr[1]) tmem[tgt_addr[7:2]][31:16] <= bp_ad_o[31:16];
               else             tmem[tgt_addr[7:2]][15:0]  <= bp_ad_o[15:0];
            end
         end else begin
            tgt_cnt <= tgt_cnt + 1;
         end
      end
   end

   // ---------------- scoreboard ----------------
   logic [27:0] addr_q [$];
   logic [16:0] wr_q [$];
   logic [15:0] rd_q [$];

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         if (bp_start) begin
            logic [27:0] ea;
            ea = (addr_q.size() > 0) ? addr_q.pop_front() : 28'hFFFFFFF;
            chk(bp_ad_o[27:0] == ea, "R2", "address cycle lines", bp_ad_o[27:0], ea);
            chk(bp_ad_o[31:28] == 4'h0 && bp_ad_oe, "R2", "upper lines/oe", bp_ad_o[31:28], 0);
         end
         if (tgt_in_data && bp_ack && tgt_we) begin
            logic [16:0] ew;
            logic [15:0] lane, other;
            ew    = (wr_q.size() > 0) ? wr_q.pop_front() : 17'h1FFFF;
            lane  = ew[16] ? bp_ad_o[31:16] : bp_ad_o[15:0];
            other = ew[16] ? bp_ad_o[15:0]  : bp_ad_o[31:16];
            chk(bp_ad_oe && lane == ew[15:0], "R3", "write data on lane", lane, ew[15:0]);
            chk(other == 16'h0, "R6", "unused lane zero", other, 0);
         end
         if (cpu_req && cpu_ready && !cpu_we && !cpu_local) begin
            logic [15:0] er;
            er = (rd_q.size() > 0) ? rd_q.pop_front() : 16'hDEAD;
            chk(cpu_rdata == er, "R5", "read data", cpu_rdata, er);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic xfer(input bit loc, input bit we, input bit dop,
                       input logic [27:0] a, input logic [15:0] d, output int n);
      cpu_req = 1'b1; cpu_local = loc; cpu_we = we; cpu_dop = dop;
      cpu_addr = a; cpu_wdata = d;
      if (!loc) begin
         addr_q.push_back(a);
         if (we) wr_q.push_back({a[1], d});
         else    rd_q.push_back(no_ack ? 16'hFFFF : ref16[a[7:1]]);
      end
      if (we && !loc) ref16[a[7:1]] = d;
      #1;
      n = 0;
      while (!cpu_ready) begin
         @(negedge clk); #1;
         n++;
      end
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R4 watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      for (int i = 0; i < 64; i++)
         tmem[i] = {16'hA001 + 16'(2*i), 16'hA000 + 16'(2*i)};
      for (int j = 0; j < 128; j++)
         ref16[j] = 16'hA000 + 16'(j);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state
      chk(bp_start == 0, "R1", "bp_start after reset", bp_start, 0);
      chk(bp_ad_oe == 0, "R1", "bp_ad_oe after reset", bp_ad_oe, 0);
      chk(bus_err == 0, "R1", "bus_err after reset", bus_err, 0);
      chk(cpu_ready == 0, "R1", "cpu_ready after reset", cpu_ready, 0);
      @(negedge clk);

      // R4/R5: read, no wait, lane 0
      wait_n = 0;
      xfer(0, 0, 0, 28'hABCDE10, 16'h0, n);
      chk(n == 2, "R4", "read latency W=0", n, 2);
      // R4/R5: read, 2 waits, lane 1
      wait_n = 2;
      xfer(0, 0, 0, 28'h5A5A712, 16'h0, n);
      chk(n == 4, "R4", "read latency W=2", n, 4);

      // R11: non-posted write waits for ack
      wait_n = 1;
      xfer(0, 1, 0, 28'h1234506, 16'h1234, n);
      chk(n == 3, "R11", "plain write latency W=1", n, 3);
      xfer(0, 0, 0, 28'h1234506, 16'h0, n);
      chk(n == 3, "R5", "readback latency W=1", n, 3);
      xfer(0, 0, 0, 28'h1234504, 16'h0, n);   // R6: other lane untouched

      // R7/R8: posted write then read held behind it
      wait_n = 0;
      xfer(0, 1, 1, 28'h0F00020, 16'hBEEF, n);
      chk(n == 0, "R7", "posted write ready at once", n, 0);
      xfer(0, 0, 0, 28'h0F00022, 16'h0, n);
      chk(n == 4, "R8", "read behind posted write W=0", n, 4);
      xfer(0, 0, 0, 28'h0F00020, 16'h0, n);

      wait_n = 1;
      xfer(0, 1, 1, 28'h0F00024, 16'hCAFE, n);
      chk(n == 0, "R7", "posted write ready W=1", n, 0);
      xfer(0, 0, 0, 28'h0F00026, 16'h0, n);
      chk(n == 6, "R8", "read behind posted write W=1", n, 6);

      // R8: second posted write waits for first
      wait_n = 0;
      xfer(0, 1, 1, 28'h0F00030, 16'h1111, n);
      xfer(0, 1, 1, 28'h0F00032, 16'h2222, n);
      chk(n == 2, "R8", "second posted write held", n, 2);

      // R9: local access while posted write in flight
      wait_n = 3;
      xfer(0, 1, 1, 28'h0F00040, 16'h4444, n);
      xfer(1, 0, 0, 28'h0000100, 16'h0, n);
      chk(n == 0, "R9", "local access ready at once", n, 0);
      xfer(0, 0, 0, 28'h0F00040, 16'h0, n);
      xfer(0, 0, 0, 28'h0F00030, 16'h0, n);
      xfer(0, 0, 0, 28'h0F00032, 16'h0, n);

      // R10: timeout
      no_ack = 1;
      xfer(0, 0, 0, 28'h7700050, 16'h0, n);
      chk(n == 256, "R10", "abort latency", n, 256);
      #1;
      chk(bus_err == 1, "R10", "bus_err raised", bus_err, 1);
      no_ack = 0;
      @(negedge clk); #1;
      chk(bus_err == 0, "R10", "bus_err one clock", bus_err, 0);
      @(negedge clk);
      wait_n = 0;
      xfer(0, 0, 0, 28'h7700050, 16'h0, n);
      chk(n == 2, "R4", "read after abort", n, 2);

      repeat (3) @(negedge clk);
      chk(addr_q.size() == 0 && wr_q.size() == 0 && rd_q.size() == 0,
          "R2", "scoreboard drained", addr_q.size() + wr_q.size() + rd_q.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule